// File: doc/BRIEF.md
# Supply Level Reset Supervisor

This block turns a digitized supply-level code and an active-low manual reset request into a clean, active-low system reset. It pulls the reset low as soon as either cause appears. The only exception is the level path, which first has to see the fault persist for a short qualification window. The reset is let go only after every cause has cleared and a release delay has run out completely.

The release delay comes from one of three sources, chosen by a two-bit mode input. Two of them are fixed presets, a short one and a long one. The third is a programmed value: a user count scaled by a step size, plus a fixed offset. All delays are given in microseconds and are turned into clock cycles from the clock frequency parameter.

A level fault clears only when the level climbs to the threshold plus a hysteresis amount. The fault is raised when the level drops below the bare threshold. Any new fault while the release delay is running sends the delay back to zero.

Top module: `supply_supervisor`

## Requirements
- R1: A level code strictly below `thresh` for QUAL_CYC consecutive clock cycles raises the level fault, and `rst_out_n` goes low on the following clock edge (QUAL_CYC+1 edges after the level first drops).
- R2: A dip below `thresh` lasting fewer than QUAL_CYC consecutive cycles has no effect on `rst_out_n`, and any cycle at or above `thresh` restarts the qualification count.
- R3: `man_rst_n` passes through a two-stage synchronizer: a low level drives `rst_out_n` low on the third clock edge after it is applied.
- R4: An active level fault clears only once the level code is at or above `thresh + hyst`. A level between `thresh` and `thresh + hyst` keeps an active fault in place.
- R5: `rst_out_n` goes high only after the level fault is clear and the synchronized manual reset is high, and then only after the selected delay of T cycles has fully elapsed. For a manual reset release, high comes T+2 edges after `man_rst_n` rises. For a level release, it comes T+1 edges after the level reaches `thresh + hyst`.
- R6: Any new fault while the release delay is counting drives the count back to zero. The full delay is needed again once all faults clear.
- R7: `delay_sel` encoding: 2'b00 selects the short preset (SHORT_US), 2'b01 the long preset (LONG_US), and 2'b10 or 2'b11 the programmed delay of `prog_delay`×STEP_US + OFFSET_US. Each value is converted to cycles as CLK_HZ×µs/10^6.
- R8: While `rst` is high, `rst_out_n` is low on the next edge. After `rst` the level is treated as faulted until it reaches `thresh + hyst`, and the full selected delay must run before release.
- R9: Once released, `rst_out_n` stays high while there is no fault. A level at or above `thresh`, even one inside the hysteresis band, does not pull it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| level_code | input | LVL_W | Digitized monitored supply level |
| thresh | input | LVL_W | Fault threshold; below this is a fault |
| hyst | input | LVL_W | Extra margin above threshold needed to clear a fault |
| man_rst_n | input | 1 | Asynchronous active-low manual reset request |
| delay_sel | input | 2 | Release delay mode (see R7) |
| prog_delay | input | PROG_W | User delay count in STEP_US units |
| rst_out_n | output | 1 | Registered active-low reset output |

## Verification
The bench builds the block at a 10 kHz nominal clock with an 8-bit level code, an 8-bit programmed count and a four-cycle qualification window. At these settings the short and long presets are 200 and 3000 cycles, one programmed step is one cycle, and the offset is five cycles. This makes every preset, the zero programmed value and the restart of the delay reachable in a few thousand cycles. The exact edge on which the output changes can be checked on both sides for each path. Directed runs then apply the block reset while the level sits inside the hysteresis band.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    DLY_SHORT    = 2'b00,
    DLY_LONG     = 2'b01,
    DLY_PROG     = 2'b10,
    DLY_PROG_ALT = 2'b11
  } dly_mode_e;

  function automatic longint us_to_cyc(input longint hz, input longint us);
    return (hz * us) / 64'sd1000000;
  endfunction

  function automatic longint max3(input longint a, input longint b, input longint c);
    longint m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_mr_sync.sv
module sup_mr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);

  logic [STAGES-1:0] q;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else if (i == 0) q[i] <= async_n;
        else q[i] <= q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_n = q[STAGES-1];

endmodule

// File: rtl/sup_level_qual.sv
module sup_level_qual #(
  parameter int LVL_W    = 10,
  parameter int QUAL_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] hyst,
  output logic             fault
);

  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] qcnt;
  logic          below;
  logic          above_rel;
  logic [LVL_W:0] rel_lvl;

  assign rel_lvl   = {1'b0, thresh} + {1'b0, hyst};
  assign below     = (level < thresh);
  assign above_rel = ({1'b0, level} >= rel_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt  <= '0;
      fault <= 1'b1;
    end else if (below) begin
      if (qcnt == QLAST) fault <= 1'b1;
      else qcnt <= qcnt + QW'(1);
    end else begin
      qcnt <= '0;
      if (above_rel) fault <= 1'b0;
    end
  end

endmodule

// File: rtl/sup_delay_sel.sv
module sup_delay_sel
  import sup_pkg::*;
#(
  parameter int     CNT_W      = 24,
  parameter int     PROG_W     = 17,
  parameter longint SHORT_CYC  = 20000,
  parameter longint LONG_CYC   = 300000,
  parameter longint STEP_CYC   = 100,
  parameter longint OFFSET_CYC = 500
) (
  input  logic [1:0]        delay_sel,
  input  logic [PROG_W-1:0] prog_delay,
  output logic [CNT_W-1:0]  target
);

  logic [CNT_W-1:0] prog_ext;
  logic [CNT_W-1:0] prog_cyc;

  assign prog_ext = CNT_W'(prog_delay);
  assign prog_cyc = prog_ext * CNT_W'(STEP_CYC) + CNT_W'(OFFSET_CYC);

  always_comb begin
    case (dly_mode_e'(delay_sel))
      DLY_SHORT: target = CNT_W'(SHORT_CYC);
      DLY_LONG:  target = CNT_W'(LONG_CYC);
      default:   target = prog_cyc;
    endcase
  end

endmodule

// File: rtl/sup_release_timer.sv
module sup_release_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_any,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             out_n
);

  always_ff @(posedge clk) begin
    if (rst || fault_any) begin
      cnt   <= '0;
      out_n <= 1'b0;
    end else if (!out_n) begin
      if ((cnt + CNT_W'(1)) >= target) out_n <= 1'b1;
      else cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int          LVL_W     = 10,
  parameter int          PROG_W    = 17,
  parameter int          QUAL_CYC  = 20,
  parameter int unsigned CLK_HZ    = 1000000,
  parameter int unsigned SHORT_US  = 20000,
  parameter int unsigned LONG_US   = 300000,
  parameter int unsigned STEP_US   = 100,
  parameter int unsigned OFFSET_US = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  level_code,
  input  logic [LVL_W-1:0]  thresh,
  input  logic [LVL_W-1:0]  hyst,
  input  logic              man_rst_n,
  input  logic [1:0]        delay_sel,
  input  logic [PROG_W-1:0] prog_delay,
  output logic              rst_out_n
);

  localparam longint SHORT_CYC  = sup_pkg::us_to_cyc(longint'(CLK_HZ), longint'(SHORT_US));
  localparam longint LONG_CYC   = sup_pkg::us_to_cyc(longint'(CLK_HZ), longint'(LONG_US));
  localparam longint STEP_CYC   = sup_pkg::us_to_cyc(longint'(CLK_HZ), longint'(STEP_US));
  localparam longint OFFSET_CYC = sup_pkg::us_to_cyc(longint'(CLK_HZ), longint'(OFFSET_US));
  localparam longint PROG_MAX   = ((longint'(1) << PROG_W) - 1) * STEP_CYC + OFFSET_CYC;
  localparam longint MAX_CYC    = sup_pkg::max3(SHORT_CYC, LONG_CYC, PROG_MAX);
  localparam int     CNT_W      = $clog2(MAX_CYC + 1);

  logic             mr_s;
  logic             lvl_fault;
  logic             fault_any;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] tmr_cnt;

  sup_mr_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (man_rst_n),
    .sync_n  (mr_s)
  );

  sup_level_qual #(.LVL_W(LVL_W), .QUAL_CYC(QUAL_CYC)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .level  (level_code),
    .thresh (thresh),
    .hyst   (hyst),
    .fault  (lvl_fault)
  );

  sup_delay_sel #(
    .CNT_W      (CNT_W),
    .PROG_W     (PROG_W),
    .SHORT_CYC  (SHORT_CYC),
    .LONG_CYC   (LONG_CYC),
    .STEP_CYC   (STEP_CYC),
    .OFFSET_CYC (OFFSET_CYC)
  ) u_dsel (
    .delay_sel  (delay_sel),
    .prog_delay (prog_delay),
    .target     (target)
  );

  assign fault_any = lvl_fault | ~mr_s;

  sup_release_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .fault_any (fault_any),
    .target    (target),
    .cnt       (tmr_cnt),
    .out_n     (rst_out_n)
  );

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int LVL_W = 10,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] level_code,
  input logic [LVL_W-1:0] thresh,
  input logic [LVL_W-1:0] hyst,
  input logic             mr_s,
  input logic             lvl_fault,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             rst_out_n
);

  AST_FAULT_SET_NEEDS_BELOW: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_fault) |-> $past(level_code < thresh)); // R1

  AST_MR_LOW_PULLS_OUT: assert property (@(posedge clk) disable iff (rst)
    !mr_s |=> !rst_out_n); // R3

  AST_FAULT_CLEAR_NEEDS_HYST: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl_fault) |-> $past({1'b0, level_code} >= ({1'b0, thresh} + {1'b0, hyst}))); // R4

  AST_RELEASE_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> $past(mr_s && !lvl_fault)); // R5

  AST_COUNT_CLEARED_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    (lvl_fault || !mr_s) |=> (tmr_cnt == '0)); // R6

  AST_HIGH_HOLDS_WITHOUT_FAULT: assert property (@(posedge clk) disable iff (rst)
    (rst_out_n && mr_s && !lvl_fault) |=> rst_out_n); // R9

endmodule

bind supply_supervisor sup_checker #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .level_code (level_code),
  .thresh     (thresh),
  .hyst       (hyst),
  .mr_s       (mr_s),
  .lvl_fault  (lvl_fault),
  .tmr_cnt    (tmr_cnt),
  .rst_out_n  (rst_out_n)
);

// File: tb/tb_supply_supervisor.sv
module tb_supply_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int PROG_W     = 8;
  localparam int NVEC       = 33;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LVL_W-1:0]  level_code = 8'd150;
  logic [LVL_W-1:0]  thresh = 8'd100;
  logic [LVL_W-1:0]  hyst = 8'd10;
  logic              man_rst_n = 1'b1;
  logic [1:0]        delay_sel = 2'd0;
  logic [PROG_W-1:0] prog_delay = 8'd20;
  logic              rst_out_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_supervisor #(
    .LVL_W(LVL_W), .PROG_W(PROG_W), .QUAL_CYC(4), .CLK_HZ(10000),
    .SHORT_US(20000), .LONG_US(300000), .STEP_US(100), .OFFSET_US(500)
  ) dut (
    .clk(clk), .rst(rst), .level_code(level_code), .thresh(thresh), .hyst(hyst),
    .man_rst_n(man_rst_n), .delay_sel(delay_sel), .prog_delay(prog_delay),
    .rst_out_n(rst_out_n)
  );

  typedef struct packed {
    logic [7:0]  lvl;
    logic        mr_n;
    logic [1:0]  sel;
    logic [7:0]  prog;
    logic [15:0] n;
    logic        exp;
  } vec_t;

  // thresh=100, hyst=10; short=200, long=3000, prog=p+5 cycles
  localparam vec_t VECS [0:NVEC-1] = '{
    '{8'd150, 1'b1, 2'd0, 8'd20, 16'd1,    1'b0}, // R8 low after reset
    '{8'd150, 1'b1, 2'd0, 8'd20, 16'd200,  1'b0}, // R7 short not done
    '{8'd150, 1'b1, 2'd0, 8'd20, 16'd1,    1'b1}, // R7 short done
    '{8'd90,  1'b1, 2'd0, 8'd20, 16'd3,    1'b1}, // R2 short dip
    '{8'd150, 1'b1, 2'd0, 8'd20, 16'd5,    1'b1}, // R2
    '{8'd90,  1'b1, 2'd0, 8'd20, 16'd4,    1'b1}, // R1 edge before
    '{8'd90,  1'b1, 2'd0, 8'd20, 16'd1,    1'b0}, // R1 asserted
    '{8'd105, 1'b1, 2'd0, 8'd20, 16'd50,   1'b0}, // R4 band holds fault
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd25,   1'b0}, // R5 level release
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd1,    1'b1}, // R5
    '{8'd105, 1'b1, 2'd2, 8'd20, 16'd20,   1'b1}, // R9 band no assert
    '{8'd150, 1'b0, 2'd2, 8'd20, 16'd2,    1'b1}, // R3 sync latency
    '{8'd150, 1'b0, 2'd2, 8'd20, 16'd1,    1'b0}, // R3
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd26,   1'b0}, // R5 mr release
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd1,    1'b1}, // R5
    '{8'd150, 1'b0, 2'd2, 8'd20, 16'd3,    1'b0}, // R6
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd15,   1'b0}, // R6 partial count
    '{8'd150, 1'b0, 2'd2, 8'd20, 16'd3,    1'b0}, // R6 new fault
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd26,   1'b0}, // R6 full delay again
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd1,    1'b1}, // R6
    '{8'd90,  1'b0, 2'd2, 8'd20, 16'd10,   1'b0}, // R5 both faults
    '{8'd90,  1'b1, 2'd2, 8'd20, 16'd40,   1'b0}, // R5 level still bad
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd25,   1'b0}, // R5
    '{8'd150, 1'b1, 2'd2, 8'd20, 16'd1,    1'b1}, // R5
    '{8'd150, 1'b0, 2'd2, 8'd20, 16'd3,    1'b0}, // R7
    '{8'd150, 1'b1, 2'd1, 8'd20, 16'd3001, 1'b0}, // R7 long not done
    '{8'd150, 1'b1, 2'd1, 8'd20, 16'd1,    1'b1}, // R7 long done
    '{8'd150, 1'b0, 2'd1, 8'd20, 16'd3,    1'b0}, // R7
    '{8'd150, 1'b1, 2'd3, 8'd40, 16'd46,   1'b0}, // R7 mode 3 prog
    '{8'd150, 1'b1, 2'd3, 8'd40, 16'd1,    1'b1}, // R7
    '{8'd150, 1'b0, 2'd3, 8'd40, 16'd3,    1'b0}, // R7
    '{8'd150, 1'b1, 2'd2, 8'd0,  16'd6,    1'b0}, // R7 prog zero = offset
    '{8'd150, 1'b1, 2'd2, 8'd0,  16'd1,    1'b1}  // R7
  };

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (rst_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_out_n=%0b expected %0b", tag, rst_out_n, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      level_code = VECS[i].lvl;
      man_rst_n  = VECS[i].mr_n;
      delay_sel  = VECS[i].sel;
      prog_delay = VECS[i].prog;
      wait_edges(int'(VECS[i].n));
      check(VECS[i].exp, $sformatf("vector %0d (R1..R9 table)", i));
    end

    // R8: reset forces low on next edge, then full short delay
    rst = 1'b1;
    delay_sel = 2'd0;
    wait_edges(1);
    check(1'b0, "R8 reset pulls low");
    wait_edges(2);
    rst = 1'b0;
    wait_edges(201);
    check(1'b0, "R8 short delay not done after reset");
    wait_edges(1);
    check(1'b1, "R8 released after reset");

    // R8: level in hysteresis band after reset counts as faulted
    rst = 1'b1;
    level_code = 8'd105;
    wait_edges(3);
    rst = 1'b0;
    wait_edges(400);
    check(1'b0, "R8 band level held as fault");
    level_code = 8'd150;
    wait_edges(200);
    check(1'b0, "R4 release delay running");
    wait_edges(1);
    check(1'b1, "R4 released");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule